// File: doc/BRIEF.md
# Packed Exponent Difference Unit

This unit is the exponent-compare front end of a floating-point adder. It works on 64-bit operand words that hold either one double-precision value or two single-precision values. In double mode it returns the signed difference of the two 11-bit exponents. In packed-single mode it returns two independent signed differences, one for each 32-bit lane. The mantissa-alignment stage that follows uses these differences to choose a shift amount and a swap direction.

All lanes share one 16-bit subtractor built around left-aligned operands. The upper exponent byte always sits in the top byte. In double mode the three extra low exponent bits sit just below it. In single mode the lower-lane exponent fills the low byte, and the carry path across the byte boundary is cut. The subtraction is spread over two register stages. The first stage forms partial differences for the upper byte (one for each possible carry-in), for the 3-bit extension and for the low byte. The second stage resolves the carry by selection and joins the pieces. A new operand pair can enter every cycle. The mode bit travels down the pipeline with its data.

Top module: `fpx_expdiff`

## Requirements
- R1: With `dbl_mode`=1, `diff_dbl` equals the 12-bit two's-complement value of op_a[62:52] minus op_b[62:52], and both `diff_up` and `diff_lo` read zero. Bits 30:23 do not affect the result in this mode.
- R2: With `dbl_mode`=0, `diff_up` equals the 9-bit two's-complement value of op_a[62:55] minus op_b[62:55], and `diff_dbl` reads zero.
- R3: With `dbl_mode`=0, `diff_lo` equals the 9-bit two's-complement value of op_a[30:23] minus op_b[30:23].
- R4: In packed-single mode a borrow out of the lower lane never alters `diff_up`, and operand bits 54:52 have no effect on either lane.
- R5: Results appear exactly two clock edges after their inputs are sampled. `out_valid` and `out_dbl_mode` repeat the `in_valid` and `dbl_mode` of that pair, and one pair is accepted every cycle, including when the mode alternates between consecutive pairs.
- R6: While `out_valid` is 0, all three difference outputs are zero. A pair presented with `in_valid`=0 produces no valid result.
- R7: Equal exponents give a zero difference with a clear sign bit in every active lane.
- R8: No result ever takes the most negative code of its width (12'h800 or 9'h100).
- R9: After synchronous reset, `out_valid` is 0 and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| dbl_mode | input | 1 | 1 = one double per word, 0 = two packed singles |
| op_a | input | 64 | Minuend operand word |
| op_b | input | 64 | Subtrahend operand word |
| out_valid | output | 1 | Result present |
| out_dbl_mode | output | 1 | Mode of the pair whose result is present |
| diff_dbl | output | 12 | Signed double exponent difference |
| diff_up | output | 9 | Signed upper-lane single exponent difference |
| diff_lo | output | 9 | Signed lower-lane single exponent difference |

## Verification
The assertions assume that reset is held for at least one edge before the first operand pair, and that `dbl_mode` and the operands are known whenever `in_valid` is high. The stimulus drives every input to a defined value on the falling edge, including during reset and idle cycles. It mixes seeded random words with a bias toward equal exponents and lanes near the wrap-around, and it adds directed pairs at the all-zero and all-one exponent limits, lower-lane borrows and modes that alternate on consecutive cycles.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int WORD_W     = 64;
    localparam int SGL_EXP_W  = 8;
    localparam int DBL_EXP_W  = 11;
    localparam int UP_EXP_MSB = 62;
    localparam int LO_EXP_MSB = 30;

    localparam int EXT_W      = DBL_EXP_W - SGL_EXP_W;
    localparam int SUB_W      = 2 * SGL_EXP_W;
    localparam int PAD_W      = SGL_EXP_W - EXT_W;
    localparam int UP_EXP_LSB = UP_EXP_MSB - SGL_EXP_W + 1;
    localparam int EXT_MSB    = UP_EXP_LSB - 1;
    localparam int EXT_LSB    = EXT_MSB - EXT_W + 1;
    localparam int LO_EXP_LSB = LO_EXP_MSB - SGL_EXP_W + 1;
    localparam int DIFF_DW    = DBL_EXP_W + 1;
    localparam int DIFF_SW    = SGL_EXP_W + 1;

    typedef enum logic {
        MODE_SGL = 1'b0,
        MODE_DBL = 1'b1
    } mode_e;

    typedef struct packed {
        logic                 cout;
        logic [SGL_EXP_W-1:0] sum;
    } byte_res_t;

    typedef struct packed {
        logic             cout;
        logic [EXT_W-1:0] sum;
    } ext_res_t;

    typedef struct packed {
        byte_res_t hi_c0;
        byte_res_t hi_c1;
        ext_res_t  ext;
        byte_res_t lo;
    } part_t;

    typedef struct packed {
        logic [DIFF_DW-1:0] dbl;
        logic [DIFF_SW-1:0] up;
        logic [DIFF_SW-1:0] lo;
    } diff_t;

    localparam logic [DIFF_DW-1:0] DBL_MIN_CODE = {1'b1, {DBL_EXP_W{1'b0}}};
    localparam logic [DIFF_SW-1:0] SGL_MIN_CODE = {1'b1, {SGL_EXP_W{1'b0}}};

    // carry out of a + ~b + 1 is set when a >= b, so the sign is its inverse
    function automatic logic [DIFF_SW-1:0] byte_to_signed(input byte_res_t r);
        return {~r.cout, r.sum};
    endfunction

endpackage

// File: rtl/fpx_sub_slice.sv
module fpx_sub_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int RW = W + 1;

    logic [RW-1:0] total;

    always_comb begin
        total = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
        sum   = total[W-1:0];
        cout  = total[W];
    end
endmodule

// File: rtl/fpx_operand_pack.sv
module fpx_operand_pack
    import fpx_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  mode_e             mode,
    output logic [SUB_W-1:0]  ea,
    output logic [SUB_W-1:0]  eb,
    output logic              split
);
    always_comb begin
        ea = '0;
        eb = '0;
        ea[SUB_W-1 -: SGL_EXP_W] = op_a[UP_EXP_MSB:UP_EXP_LSB];
        eb[SUB_W-1 -: SGL_EXP_W] = op_b[UP_EXP_MSB:UP_EXP_LSB];
        if (mode == MODE_DBL) begin
            ea[SGL_EXP_W-1 -: EXT_W] = op_a[EXT_MSB:EXT_LSB];
            eb[SGL_EXP_W-1 -: EXT_W] = op_b[EXT_MSB:EXT_LSB];
            split = 1'b0;
        end else begin
            ea[SGL_EXP_W-1:0] = op_a[LO_EXP_MSB:LO_EXP_LSB];
            eb[SGL_EXP_W-1:0] = op_b[LO_EXP_MSB:LO_EXP_LSB];
            split = 1'b1;
        end
    end
endmodule

// File: rtl/fpx_stage1.sv
module fpx_stage1
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  mode_e            mode_i,
    input  logic [SUB_W-1:0] ea,
    input  logic [SUB_W-1:0] eb,
    input  logic             split_i,
    output logic             valid_q,
    output mode_e            mode_q,
    output logic             split_q,
    output part_t            part_q
);
    byte_res_t hi_res [2];
    ext_res_t  ext_res;
    byte_res_t lo_res;
    part_t     part_d;

    // upper byte precomputed for both carry-in values (carry-select)
    for (genvar g = 0; g < 2; g++) begin : g_hi
        fpx_sub_slice #(.W(SGL_EXP_W)) u_hi (
            .a    (ea[SUB_W-1 -: SGL_EXP_W]),
            .b    (eb[SUB_W-1 -: SGL_EXP_W]),
            .cin  (g == 1),
            .sum  (hi_res[g].sum),
            .cout (hi_res[g].cout)
        );
    end

    // zero padding below the extension always yields a carry of one
    fpx_sub_slice #(.W(EXT_W)) u_ext (
        .a    (ea[SGL_EXP_W-1 -: EXT_W]),
        .b    (eb[SGL_EXP_W-1 -: EXT_W]),
        .cin  (1'b1),
        .sum  (ext_res.sum),
        .cout (ext_res.cout)
    );

    fpx_sub_slice #(.W(SGL_EXP_W)) u_lo (
        .a    (ea[SGL_EXP_W-1:0]),
        .b    (eb[SGL_EXP_W-1:0]),
        .cin  (1'b1),
        .sum  (lo_res.sum),
        .cout (lo_res.cout)
    );

    always_comb begin
        part_d.hi_c0 = hi_res[0];
        part_d.hi_c1 = hi_res[1];
        part_d.ext   = ext_res;
        part_d.lo    = lo_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            mode_q  <= MODE_SGL;
            split_q <= 1'b0;
            part_q  <= '0;
        end else begin
            valid_q <= valid_i;
            mode_q  <= mode_i;
            split_q <= split_i;
            part_q  <= part_d;
        end
    end

    // R7: equal upper bytes give a zero sum with the carry set
    p_equal_hi_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ea[SUB_W-1 -: SGL_EXP_W] == eb[SUB_W-1 -: SGL_EXP_W])
        |=> (part_q.hi_c1.sum == '0 && part_q.hi_c1.cout));

    // R7: equal low bytes give zero with the carry set
    p_equal_lo_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ea[SGL_EXP_W-1:0] == eb[SGL_EXP_W-1:0])
        |=> (part_q.lo.sum == '0 && part_q.lo.cout));
endmodule

// File: rtl/fpx_stage2.sv
module fpx_stage2
    import fpx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid_i,
    input  mode_e mode_i,
    input  logic  split_i,
    input  part_t part_i,
    output logic  valid_q,
    output mode_e mode_q,
    output diff_t diff_q
);
    byte_res_t hi_sel;
    logic      hi_carry;
    diff_t     diff_d;

    always_comb begin
        // a broken chain feeds the upper byte its own carry-in of one
        hi_carry = split_i | part_i.ext.cout;
        hi_sel   = hi_carry ? part_i.hi_c1 : part_i.hi_c0;
        diff_d   = '0;
        if (valid_i) begin
            if (mode_i == MODE_DBL) begin
                diff_d.dbl = {~hi_sel.cout, hi_sel.sum, part_i.ext.sum};
            end else begin
                diff_d.up = byte_to_signed(hi_sel);
                diff_d.lo = byte_to_signed(part_i.lo);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            mode_q  <= MODE_SGL;
            diff_q  <= '0;
        end else begin
            valid_q <= valid_i;
            mode_q  <= mode_i;
            diff_q  <= diff_d;
        end
    end

    p_valid_follows_r5: assert property (@(posedge clk) disable iff (rst)
        valid_q == $past(valid_i));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> (diff_q == '0));

    p_dbl_lanes_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (valid_q && mode_q == MODE_DBL) |-> (diff_q.up == '0 && diff_q.lo == '0));

    p_sgl_dbl_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_q && mode_q == MODE_SGL) |-> (diff_q.dbl == '0));

    p_no_min_code_r8: assert property (@(posedge clk) disable iff (rst)
        (diff_q.dbl != DBL_MIN_CODE && diff_q.up != SGL_MIN_CODE && diff_q.lo != SGL_MIN_CODE));
endmodule

// File: rtl/fpx_expdiff.sv
module fpx_expdiff
    import fpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        dbl_mode,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    output logic        out_valid,
    output logic        out_dbl_mode,
    output logic [11:0] diff_dbl,
    output logic [8:0]  diff_up,
    output logic [8:0]  diff_lo
);
    mode_e             mode_in;
    logic [SUB_W-1:0]  ea;
    logic [SUB_W-1:0]  eb;
    logic              split;
    logic              s1_valid;
    mode_e             s1_mode;
    logic              s1_split;
    part_t             s1_part;
    mode_e             s2_mode;
    diff_t             s2_diff;

    assign mode_in = mode_e'(dbl_mode);

    fpx_operand_pack u_pack (
        .op_a  (op_a),
        .op_b  (op_b),
        .mode  (mode_in),
        .ea    (ea),
        .eb    (eb),
        .split (split)
    );

    fpx_stage1 u_s1 (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .mode_i  (mode_in),
        .ea      (ea),
        .eb      (eb),
        .split_i (split),
        .valid_q (s1_valid),
        .mode_q  (s1_mode),
        .split_q (s1_split),
        .part_q  (s1_part)
    );

    fpx_stage2 u_s2 (
        .clk     (clk),
        .rst     (rst),
        .valid_i (s1_valid),
        .mode_i  (s1_mode),
        .split_i (s1_split),
        .part_i  (s1_part),
        .valid_q (out_valid),
        .mode_q  (s2_mode),
        .diff_q  (s2_diff)
    );

    assign out_dbl_mode = (s2_mode == MODE_DBL);
    assign diff_dbl     = s2_diff.dbl;
    assign diff_up      = s2_diff.up;
    assign diff_lo      = s2_diff.lo;

    // R4: equal upper exponents in single mode give zero whatever the lower lane does
    p_upper_isolated_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dbl_mode && op_a[UP_EXP_MSB:UP_EXP_LSB] == op_b[UP_EXP_MSB:UP_EXP_LSB])
        |=> ##1 (diff_up == '0));

    // R5: the mode leaves with its data
    p_mode_travels_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && s1_valid) |=> (s1_mode == mode_e'($past(dbl_mode))));
endmodule

// File: tb/fpx_expdiff_tb.sv
`timescale 1ns/1ps
module fpx_expdiff_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        dbl_mode;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic        out_valid;
    logic        out_dbl_mode;
    logic [11:0] diff_dbl;
    logic [8:0]  diff_up;
    logic [8:0]  diff_lo;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // expected pipeline: index 0 = driven last step, 1 = driven two steps ago
    logic        ev [2];
    logic        em [2];
    logic [11:0] ed [2];
    logic [8:0]  eu [2];
    logic [8:0]  el [2];
    string       et [2];

    always #2 clk = ~clk;

    fpx_expdiff u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .dbl_mode     (dbl_mode),
        .op_a         (op_a),
        .op_b         (op_b),
        .out_valid    (out_valid),
        .out_dbl_mode (out_dbl_mode),
        .diff_dbl     (diff_dbl),
        .diff_up      (diff_up),
        .diff_lo      (diff_lo)
    );

    task automatic chk(input string tag, input string what, input logic [11:0] got, input logic [11:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic check_out();
        chk("R5", "out_valid", {11'd0, out_valid}, {11'd0, ev[1]});
        if (ev[1]) chk("R5", "out_dbl_mode", {11'd0, out_dbl_mode}, {11'd0, em[1]});
        chk(et[1], "diff_dbl", diff_dbl, ed[1]);
        chk(et[1], "diff_up", {3'd0, diff_up}, {3'd0, eu[1]});
        chk(et[1], "diff_lo", {3'd0, diff_lo}, {3'd0, el[1]});
        chk("R8", "min code seen", {11'd0, (diff_dbl == 12'h800 || diff_up == 9'h100 || diff_lo == 9'h100)}, 12'd0);
    endtask

    task automatic step(input logic v, input logic m, input logic [63:0] a, input logic [63:0] b, input string tg);
        @(negedge clk);
        check_out();
        ev[1] = ev[0]; em[1] = em[0]; ed[1] = ed[0]; eu[1] = eu[0]; el[1] = el[0]; et[1] = et[0];
        ev[0] = v;
        em[0] = m;
        ed[0] = '0; eu[0] = '0; el[0] = '0;
        if (v) begin
            if (m) begin
                ed[0] = {1'b0, a[62:52]} - {1'b0, b[62:52]};
            end else begin
                eu[0] = {1'b0, a[62:55]} - {1'b0, b[62:55]};
                el[0] = {1'b0, a[30:23]} - {1'b0, b[30:23]};
            end
        end
        et[0] = tg;
        in_valid = v; dbl_mode = m; op_a = a; op_b = b;
    endtask

    function automatic logic [63:0] mk(input logic [10:0] e_hi, input logic [7:0] e_lo, input logic [63:0] noise);
        logic [63:0] w;
        w = noise;
        w[62:52] = e_hi;
        w[30:23] = e_lo;
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] ra, rb;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            ev[i] = 1'b0; em[i] = 1'b0; ed[i] = '0; eu[i] = '0; el[i] = '0; et[i] = "R6";
        end
        rst = 1'b1; in_valid = 1'b0; dbl_mode = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9", "out_valid", {11'd0, out_valid}, 12'd0);
        chk("R9", "diff_dbl", diff_dbl, 12'd0);
        chk("R9", "diff_up", {3'd0, diff_up}, 12'd0);
        chk("R9", "diff_lo", {3'd0, diff_lo}, 12'd0);

        // R1: double limits, noise in bits 30:23 must be ignored
        step(1, 1, mk(11'h7ff, 8'h12, 64'h0), mk(11'h000, 8'hee, 64'h0), "R1");
        step(1, 1, mk(11'h000, 8'h00, 64'h0), mk(11'h7ff, 8'hff, 64'h0), "R1");
        step(1, 1, mk(11'h400, 8'h55, 64'h0), mk(11'h3ff, 8'haa, 64'h0), "R1");
        step(1, 1, mk(11'h3f8, 8'h00, 64'h0), mk(11'h3ff, 8'h00, 64'h0), "R1");
        // R7: equal exponents, both modes
        step(1, 1, mk(11'h5a5, 8'h01, 64'h0), mk(11'h5a5, 8'h80, 64'h0), "R7");
        step(1, 0, mk(11'h3c7, 8'h7f, 64'h0), mk(11'h3c2, 8'h7f, 64'h0), "R7");
        // R2 / R3: single-lane limits
        step(1, 0, mk({8'hff, 3'd0}, 8'h00, 64'h0), mk({8'h00, 3'd0}, 8'hff, 64'h0), "R2");
        step(1, 0, mk({8'h00, 3'd0}, 8'hff, 64'h0), mk({8'hff, 3'd0}, 8'h00, 64'h0), "R3");
        // R4: lower-lane borrow with equal upper exponents, bits 54:52 differ
        step(1, 0, mk({8'h80, 3'b111}, 8'h00, 64'h0), mk({8'h80, 3'b000}, 8'h01, 64'h0), "R4");
        step(1, 0, mk({8'h01, 3'b000}, 8'h00, 64'h0), mk({8'h00, 3'b111}, 8'hff, 64'h0), "R4");
        // R6: invalid pairs with nonzero operands
        step(0, 1, mk(11'h7ff, 8'hff, 64'hffff_ffff_ffff_ffff), 64'h0, "R6");
        step(0, 0, mk(11'h123, 8'h45, 64'h0), mk(11'h321, 8'h54, 64'h0), "R6");
        // R5: alternating modes back to back
        for (int i = 0; i < 8; i++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            step(1, logic'(i % 2), ra, rb, "R5");
        end
        // random mix
        for (int i = 0; i < 800; i++) begin
            logic m, v;
            string tg;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            m  = logic'($urandom_range(0, 1));
            v  = ($urandom_range(0, 7) != 0);
            case ($urandom_range(0, 5))
                0: rb[62:52] = ra[62:52];
                1: rb[30:23] = ra[30:23];
                2: begin ra[62:55] = 8'h00; rb[62:55] = 8'hff; end
                default: ;
            endcase
            tg = !v ? "R6" : (m ? "R1" : ((i % 2) ? "R2" : "R3"));
            step(v, m, ra, rb, tg);
        end
        // flush
        step(0, 0, 64'h0, 64'h0, "R6");
        step(0, 0, 64'h0, 64'h0, "R6");
        @(negedge clk);
        check_out();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule